// File: doc/BRIEF.md
# Edge-Counting Timer Channel with Quadrature Decode

This block is one 16-bit counting channel of a timer. It counts transitions of an external event input and is set up through a small write-only register port. In the single-input mode a configuration bit picks which transition (rising or falling) advances the count. The direction comes either from a software bit or from the level of a second input pin. In the quadrature mode the two pins carry phase A and phase B of an encoder. The count then advances once per phase-A rising edge, or on every edge of both phases for a times-four resolution.

When the count steps past a boundary, the channel raises a one-cycle wrap pulse. Stepping up from FFFFh or down from 0000h is a boundary step. On that step the counter either takes the value held in a reload register or simply rolls over. Both pins pass through a two-flop synchronizer, so they may be fully asynchronous to the clock. A count step appears at the output on the third rising clock edge after the input change.

Top module: `evcnt_channel`

## Requirements
- R1: After reset the count reads 0000h, the wrap pulse is low and the mode register is 00h. Counting happens only while the mode field in bits [1:0] of register address 0 equals 01b and the run bit (bit 0 of register address 2) is 1. Address 1 holds the 16-bit reload value.
- R2: In single-input mode (bit 2 of address 2 clear), bit 3 of the mode register selects the counted edge of `evt_in`: 0 counts falling edges, 1 counts rising edges. The other edge has no effect on the count.
- R3: In single-input mode, bit 4 of the mode register selects the direction source. With 0, bit 1 of address 2 decides the direction (1 up, 0 down). With 1, `dir_in` decides it (high up, low down).
- R4: `wrap_o` is high for exactly the cycle after a step up from FFFFh or a step down from 0000h, and at no other time.
- R5: With bit 6 of the mode register clear, a boundary step loads the counter with the reload register value.
- R6: With bit 6 of the mode register set, a step up from FFFFh gives 0000h and a step down from 0000h gives FFFFh.
- R7: In quadrature mode (bit 2 of address 2 set) with bit 7 of the mode register clear, each rising edge of `evt_in` moves the count by one. The count goes up if `dir_in` is low at that edge and down if it is high. No other edge has any effect.
- R8: In quadrature mode with bit 7 set, every edge of either pin moves the count by one. The sequence (A,B) 00, 10, 11, 01 counts up when run forward and down when run in reverse. A change of both pins at once does not count.
- R9: While the run bit is 0 the count holds. A write to the reload register while the run bit is 0 also loads the counter. While running, such a write changes only the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 reload, 2 control |
| wr_data | input | 16 | Write data; mode uses [7:0], control uses [2:0] |
| evt_in | input | 1 | Event input, or phase A in quadrature mode |
| dir_in | input | 1 | Direction level, or phase B in quadrature mode |
| cnt_o | output | 16 | Current count |
| wrap_o | output | 1 | One-cycle pulse after a boundary step |

## Verification
The assertions assume a reset of at least one clock and writes that are single-cycle strobes. They do not assume the pins are well-behaved: the step-size check holds for any pin activity, because the decoder steps at most once per cycle. The stimulus changes the pins only at falling clock edges and leaves five clocks after every change. This lets each change be seen as exactly one event by the synchronizer, and it lets the bench model apply changes in order. Random configurations include invalid mode fields and simultaneous two-pin changes, so the gating and no-count cases are covered within these rules.

// File: rtl/evcnt_pkg.sv
// Shared constants and types for the edge-counting timer channel.
// Assumes: register addresses and bit positions below are the software contract.
package evcnt_pkg;

    localparam int MODE_W    = 8;
    localparam int CTRL_W    = 3;

    // Register addresses on the write port
    localparam logic [1:0] ADDR_MODE   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;

    // Mode register fields
    localparam logic [1:0] OPM_EVENT = 2'b01;
    localparam int POL_BIT   = 3;
    localparam int DSRC_BIT  = 4;
    localparam int FREE_BIT  = 6;
    localparam int X4_BIT    = 7;

    // Control register fields
    localparam int RUN_BIT   = 0;
    localparam int SWUP_BIT  = 1;
    localparam int QUAD_BIT  = 2;

    // Decoded configuration handed to the edge decoder
    typedef struct packed {
        logic rise_pol;
        logic pin_dir;
        logic quad;
        logic x4;
        logic sw_up;
    } dec_cfg_t;

endpackage

// File: rtl/evcnt_sync.sv
// Multi-stage synchronizer for asynchronous input pins.
// Assumes: inputs are level signals; STAGES >= 2; outputs reset low.
module evcnt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First flop samples the raw pin
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Later flops settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= '0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/evcnt_edge_decode.sv
// Turns synchronized pin levels into a count request and a direction.
// Assumes: inputs already synchronized; at most one step per clock is produced.
module evcnt_edge_decode
    import evcnt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     a_s,
    input  logic     b_s,
    input  dec_cfg_t cfg,
    output logic     step,
    output logic     up
);

    logic a_q, b_q;
    logic a_rise, a_fall, a_chg, b_chg;

    // Keep previous samples for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= a_s;
            b_q <= b_s;
        end
    end

    assign a_rise = a_s & ~a_q;
    assign a_fall = ~a_s & a_q;
    assign a_chg  = a_s ^ a_q;
    assign b_chg  = b_s ^ b_q;

    // Select step and direction per operating variant
    always_comb begin
        if (!cfg.quad) begin
            step = cfg.rise_pol ? a_rise : a_fall;
            up   = cfg.pin_dir ? b_s : cfg.sw_up;
        end else if (!cfg.x4) begin
            step = a_rise;
            up   = ~b_s;
        end else begin
            step = a_chg ^ b_chg;
            up   = a_chg ? (a_s ^ b_s) : ~(a_s ^ b_s);
        end
    end

endmodule

// File: rtl/evcnt_core.sv
// Counter with boundary detection, reload or roll-over, and direct load.
// Assumes: load and en are not meaningful together; load wins.
module evcnt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             up,
    input  logic             free_run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] BOT = '0;

    // Advance, wrap or load the count; pulse on a boundary step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= BOT;
            wrap <= 1'b0;
        end else begin
            wrap <= 1'b0;
            if (load) begin
                cnt <= load_val;
            end else if (en) begin
                if (up) begin
                    if (cnt == TOP) begin
                        wrap <= 1'b1;
                        cnt  <= free_run ? BOT : reload_val;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    if (cnt == BOT) begin
                        wrap <= 1'b1;
                        cnt  <= free_run ? TOP : reload_val;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/evcnt_channel.sv
// Edge-counting timer channel: register port, pin synchronizer, edge
// decoder and counter. Assumes single-cycle write strobes.
module evcnt_channel
    import evcnt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             evt_in,
    input  logic             dir_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    logic [MODE_W-1:0] mode_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    logic [1:0]        pins_s;
    logic              step, up, active, load;
    dec_cfg_t          cfg;

    // Register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            ctrl_q   <= '0;
            reload_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_MODE:   mode_q   <= wr_data[MODE_W-1:0];
                ADDR_RELOAD: reload_q <= wr_data;
                ADDR_CTRL:   ctrl_q   <= wr_data[CTRL_W-1:0];
                default:     ;
            endcase
        end
    end

    // Configuration seen by the decoder
    always_comb begin
        cfg.rise_pol = mode_q[POL_BIT];
        cfg.pin_dir  = mode_q[DSRC_BIT];
        cfg.quad     = ctrl_q[QUAD_BIT];
        cfg.x4       = mode_q[X4_BIT];
        cfg.sw_up    = ctrl_q[SWUP_BIT];
    end

    assign active = ctrl_q[RUN_BIT] && (mode_q[1:0] == OPM_EVENT);
    assign load   = wr_en && (wr_addr == ADDR_RELOAD) && !ctrl_q[RUN_BIT];

    evcnt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dir_in, evt_in}),
        .q     (pins_s)
    );

    evcnt_edge_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .a_s   (pins_s[0]),
        .b_s   (pins_s[1]),
        .cfg   (cfg),
        .step  (step),
        .up    (up)
    );

    evcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (step && active),
        .up         (up),
        .free_run   (mode_q[FREE_BIT]),
        .load       (load),
        .load_val   (wr_data),
        .reload_val (reload_q),
        .cnt        (cnt_o),
        .wrap       (wrap_o)
    );

endmodule

// File: rtl/evcnt_checker.sv
// Property checker for the edge-counting timer channel, bound to the top.
// Assumes: synchronous active-low reset held for at least one clock.
module evcnt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] cnt_o,
    input logic             wrap_o,
    input logic [7:0]       mode_q,
    input logic [2:0]       ctrl_q,
    input logic [CNT_W-1:0] reload_q
);

    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] ONE = 1;

    logic rld_wr;
    assign rld_wr = wr_en && (wr_addr == 2'd1);

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q[1:0] != 2'b01) || !ctrl_q[0]) && !rld_wr |=> $stable(cnt_o) && !wrap_o); // R9

    AST_WRAP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> ($past(cnt_o) == TOP) || ($past(cnt_o) == '0)); // R4

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o && !$past(mode_q[6]) |-> cnt_o == $past(reload_q)); // R5

    AST_FREE_UP_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o && $past(mode_q[6]) && ($past(cnt_o) == TOP) |-> cnt_o == '0); // R6

    AST_FREE_DOWN_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o && $past(mode_q[6]) && ($past(cnt_o) == '0) |-> cnt_o == TOP); // R6

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o && !$past(rld_wr) |->
            (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + ONE) || (cnt_o == $past(cnt_o) - ONE)); // R8

endmodule

bind evcnt_channel evcnt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .cnt_o    (cnt_o),
    .wrap_o   (wrap_o),
    .mode_q   (mode_q),
    .ctrl_q   (ctrl_q),
    .reload_q (reload_q)
);

// File: tb/tb_evcnt_channel.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random traffic,
// compared against a transaction-level model of the requirements.
module tb_evcnt_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        evt_in = 1'b0;
    logic        dir_in = 1'b0;
    logic [15:0] cnt_o;
    logic        wrap_o;

    int checks = 0;
    int errors = 0;
    int wrap_seen = 0;
    int exp_wraps = 0;
    bit done = 0;

    logic [15:0] m_cnt = '0;
    logic [15:0] m_rld = '0;
    logic [7:0]  m_mode = '0;
    logic [2:0]  m_ctrl = '0;
    logic        m_a = 1'b0;
    logic        m_b = 1'b0;

    always #2.5 clk = ~clk;

    evcnt_channel dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .evt_in  (evt_in),
        .dir_in  (dir_in),
        .cnt_o   (cnt_o),
        .wrap_o  (wrap_o)
    );

    // Count wrap pulses, sampled away from the active edge
    always @(negedge clk) if (rst_n && wrap_o) wrap_seen++;

    // Position in the forward quadrature sequence 00,10,11,01
    function automatic int phase_idx(input logic a, input logic b);
        case ({a, b})
            2'b00: return 0;
            2'b10: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    task automatic model_step(input logic up);
        if (up) begin
            if (m_cnt == 16'hFFFF) begin
                exp_wraps++;
                m_cnt = m_mode[6] ? 16'h0000 : m_rld;
            end else m_cnt = m_cnt + 16'd1;
        end else begin
            if (m_cnt == 16'h0000) begin
                exp_wraps++;
                m_cnt = m_mode[6] ? 16'hFFFF : m_rld;
            end else m_cnt = m_cnt - 16'd1;
        end
    endtask

    task automatic check(input string req);
        checks++;
        if (cnt_o !== m_cnt || wrap_seen != exp_wraps) begin
            errors++;
            $display("FAIL %s: cnt=%h wraps=%0d expected cnt=%h wraps=%0d",
                     req, cnt_o, wrap_seen, m_cnt, exp_wraps);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            2'd0: m_mode = d[7:0];
            2'd1: begin if (!m_ctrl[0]) m_cnt = d; m_rld = d; end
            2'd2: m_ctrl = d[2:0];
            default: ;
        endcase
        repeat (2) @(negedge clk);
    endtask

    // Drive pins, predict the count, wait for it to settle
    task automatic pins(input logic a, input logic b);
        logic st, up;
        int diff;
        st = 1'b0; up = 1'b0;
        if (!m_ctrl[2]) begin
            st = m_mode[3] ? (a && !m_a) : (!a && m_a);
            up = m_mode[4] ? b : m_ctrl[1];
        end else if (!m_mode[7]) begin
            st = a && !m_a;
            up = !b;
        end else begin
            diff = (phase_idx(a, b) - phase_idx(m_a, m_b) + 4) % 4;
            st = (diff == 1) || (diff == 3);
            up = (diff == 1);
        end
        if (st && m_ctrl[0] && m_mode[1:0] == 2'b01) model_step(up);
        m_a = a; m_b = b;
        @(negedge clk);
        evt_in = a; dir_in = b;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state");
        if (wrap_o !== 1'b0) begin errors++; $display("FAIL R1: wrap=%b expected 0", wrap_o); end

        // R1: default mode 00h blocks counting even when running
        write_reg(2'd2, 16'h0003);
        pins(1, 0); pins(0, 0);
        check("R1 mode 00h gates counting");

        // R9: stopped reload write loads counter
        write_reg(2'd2, 16'h0000);
        write_reg(2'd1, 16'h0005);
        check("R9 load while stopped");

        // R2: rising-edge polarity, software up
        write_reg(2'd0, 16'h0009);
        write_reg(2'd2, 16'h0003);
        pins(1, 0);
        check("R2 rising counted");
        pins(0, 0);
        check("R2 falling ignored when rising selected");
        write_reg(2'd0, 16'h0001);
        pins(1, 0);
        check("R2 rising ignored when falling selected");
        pins(0, 0);
        check("R2 falling counted");

        // R3: software down, then pin direction
        write_reg(2'd2, 16'h0001);
        pins(1, 0); pins(0, 0);
        check("R3 software down");
        write_reg(2'd0, 16'h0019);
        pins(1, 1);
        check("R3 pin high counts up");
        pins(0, 0); pins(1, 0);
        check("R3 pin low counts down");

        // R9: reload write while running leaves the count
        write_reg(2'd2, 16'h0000);
        write_reg(2'd1, 16'h0001);
        write_reg(2'd0, 16'h0001);
        write_reg(2'd2, 16'h0001);
        write_reg(2'd1, 16'h1234);
        check("R9 running reload write changes reload only");
        pins(0, 0); pins(1, 0); pins(0, 0);
        check("R4 R5 down wrap reloads");

        // R6: free-run both directions
        write_reg(2'd2, 16'h0000);
        write_reg(2'd1, 16'h0000);
        write_reg(2'd0, 16'h0041);
        write_reg(2'd2, 16'h0001);
        pins(1, 0); pins(0, 0);
        check("R6 down from 0000h gives FFFFh");
        write_reg(2'd2, 16'h0003);
        pins(1, 0); pins(0, 0);
        check("R6 up from FFFFh gives 0000h");

        // R9: stopped holds
        write_reg(2'd2, 16'h0002);
        pins(1, 0); pins(0, 0);
        check("R9 stopped holds");

        // R7: quadrature normal rate
        write_reg(2'd0, 16'h0001);
        write_reg(2'd2, 16'h0005);
        pins(1, 0); pins(1, 1); pins(0, 1); pins(0, 0);
        check("R7 forward cycle one up");
        pins(0, 1); pins(1, 1); pins(1, 0); pins(0, 0);
        check("R7 reverse cycle one down");

        // R8: times four
        write_reg(2'd0, 16'h0081);
        pins(1, 0); pins(1, 1); pins(0, 1); pins(0, 0);
        check("R8 forward four up");
        pins(0, 1); pins(1, 1); pins(1, 0); pins(0, 0);
        check("R8 reverse four down");
        pins(1, 1);
        check("R8 both pins together ignored");
        pins(0, 0);

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom % 16;
            if (r == 0) write_reg(2'd2, 16'($urandom % 8));
            else if (r == 1) write_reg(2'd0, 16'((($urandom % 256) & 8'hD8) | 8'h01));
            else if (r == 2) write_reg(2'd0, 16'($urandom % 256));
            else if (r == 3) begin
                int k;
                k = $urandom % 4;
                write_reg(2'd1, k == 0 ? 16'hFFFF : k == 1 ? 16'h0000 : k == 2 ? 16'hFFFE : 16'($urandom));
            end else pins(logic'($urandom % 2), logic'($urandom % 2));
            check("R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

endmodule